// File: doc/BRIEF.md
# Symmetric PWM Channel with Complementary Dead-Band Outputs

This block generates one pulse-width-modulated channel whose time base counts up to a programmable top value and then back down to zero, so every period is centred on the top value. A comparator drives the raw waveform high when the counter passes the compare value on the way up, and low when it passes the compare value on the way down. A dead-band stage then builds two outputs from that waveform. One path delays only rising edges and the other delays only falling edges, so a pair of power switches can be driven with guaranteed off-time between them.

The counter advances on a time-base tick. The tick comes from a two-stage clock prescaler. New compare values are taken into use only when the counter is at zero, so a duty update never splits a period. A downward compare match is also counted by an event divider, which raises a sticky interrupt flag. The flag stays set until software clears it, and the `irq` output shows it only while the interrupt is enabled.

Top module: `sympwm_db`

## Requirements
- R1: The time-base tick fires once every N clock cycles, with N = 2^`clk_div_sel` × H. H is 1 when `hs_div_sel` is 0 and 2 × `hs_div_sel` otherwise. One full PWM period lasts 2 × `period` × N clock cycles.
- R2: The counter moves by exactly one step on each tick and holds between ticks. It rises from 0 to `period`, then falls back to 0.
- R3: The raw waveform goes high on the tick that leaves `cmp` going up and low on the tick that leaves `cmp` going down. It is therefore high for 2 × (`period` − `cmp`) ticks and low for 2 × `cmp` ticks in each period.
- R4: A value written to `cmp_val` takes effect only from the tick at which the counter is at 0. A pulse already in progress keeps its old width.
- R5: The rising-edge path goes high `rise_dly` ticks after the raw waveform rises and falls with the raw waveform, so a raw pulse of W ticks becomes W − `rise_dly` ticks. A raw pulse of `rise_dly` ticks or fewer produces no high output at all.
- R6: The falling-edge path rises with the raw waveform and stays high `fall_dly` ticks after the raw waveform falls. In the complementary setting the two outputs are never high together. They are separated by `rise_dly` and `fall_dly` ticks of off-time.
- R7: `out_sel` bit 1 routes the rising-edge path to A (otherwise A takes the undelayed waveform). `out_sel` bit 0 routes the falling-edge path to B (otherwise B takes the undelayed waveform). `pol_sel` bit 0 inverts A and bit 1 inverts B. The undelayed waveform has the same one-cycle latency as a zero-delay path.
- R8: A compare match on a downward tick is an event. The interrupt flag sets on every `evt_div`-th event (1, 2 or 3). When `evt_div` is 0 the flag never sets.
- R9: Once set, the interrupt flag stays set until a cycle with `irq_clr` high clears it. `irq` is high only while both the flag and `irq_en` are high. A flag set while `irq_en` is low appears on `irq` as soon as `irq_en` rises.
- R10: While `rst_n` is low, the counter and all pulse state are cleared. `pwm_a` and `pwm_b` equal their polarity-invert bits, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div_sel | input | 3 | Power-of-two prescale select |
| hs_div_sel | input | 3 | Even prescale select (0 means divide by 1) |
| period | input | 16 | Top value of the up-down counter |
| cmp_val | input | 16 | Compare value, loaded into use at counter zero |
| rise_dly | input | 16 | Rising-edge delay in ticks |
| fall_dly | input | 16 | Falling-edge delay in ticks |
| out_sel | input | 2 | Output source select for A (bit 1) and B (bit 0) |
| pol_sel | input | 2 | Output inversion for A (bit 0) and B (bit 1) |
| evt_div | input | 2 | Number of events per interrupt (0 disables) |
| irq_en | input | 1 | Interrupt output enable |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| irq | output | 1 | Interrupt request level |

## Verification
The raw waveform changes one clock after the tick edge that causes it. Both outputs then change one more clock later, whether or not a delay is selected, and each delay adds exactly its programmed number of ticks. The interrupt flag rises on the same edge that lowers the raw waveform. The bench therefore does not predict the absolute edge times. It samples at falling clock edges and measures high and low run lengths and gaps between interrupt rises, and these intervals follow directly from the requirements. Every configuration is applied under reset, so each measurement starts from a known counter phase. The shadow-compare test changes the compare value at the first sample after a rising edge, when the counter is already past zero.

// File: rtl/sympwm_pkg.sv
package sympwm_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } cnt_dir_e;
endpackage

// File: rtl/sympwm_prescale.sv
module sympwm_prescale #(
    parameter int CKDIV_W = 3,
    parameter int HSP_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CKDIV_W-1:0] clk_div_sel,
    input  logic [HSP_W-1:0]   hs_div_sel,
    output logic               tick
);
    localparam int CK_MAX  = (1 << CKDIV_W) - 1;
    localparam int HSP_MAX = 2 * ((1 << HSP_W) - 1);
    localparam int PS_W    = $clog2((1 << CK_MAX) * HSP_MAX + 1);

    typedef struct packed {
        logic [PS_W-1:0] cnt;
    } ps_state_t;

    ps_state_t state_d, state_q;
    logic [PS_W-1:0] hs_factor;
    logic [PS_W-1:0] ratio;

    always_comb begin
        hs_factor = (hs_div_sel == '0) ? PS_W'(1) : PS_W'({hs_div_sel, 1'b0});
        ratio     = (PS_W'(1) << clk_div_sel) * hs_factor;
        tick      = (state_q.cnt >= ratio - PS_W'(1));
        state_d   = state_q;
        state_d.cnt = tick ? '0 : state_q.cnt + PS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ratio != PS_W'(1)) |=> (!tick || ratio == PS_W'(1))); // R1
endmodule

// File: rtl/sympwm_timebase.sv
module sympwm_timebase
    import sympwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             raw,
    output logic             down_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cnt_dir_e         dir;
        logic [CNT_W-1:0] cmp_act;
        logic             raw;
    } tb_state_t;

    tb_state_t state_d, state_q;
    logic up_step;
    logic at_cmp;

    always_comb begin
        up_step  = (state_q.dir == DIR_UP && state_q.cnt < period) ||
                   (state_q.dir == DIR_DOWN && state_q.cnt == '0);
        at_cmp   = (state_q.cnt == state_q.cmp_act);
        down_evt = tick && at_cmp && !up_step;
        state_d  = state_q;
        if (tick) begin
            if (up_step) begin
                state_d.dir = DIR_UP;
                state_d.cnt = state_q.cnt + CNT_W'(1);
                if (at_cmp) state_d.raw = 1'b1;
            end else begin
                state_d.dir = DIR_DOWN;
                state_d.cnt = state_q.cnt - CNT_W'(1);
                if (at_cmp) state_d.raw = 1'b0;
            end
            if (state_q.cnt == '0) state_d.cmp_act = cmp_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.cnt     <= '0;
            state_q.dir     <= DIR_DOWN;
            state_q.cmp_act <= '1;
            state_q.raw     <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign raw = state_q.raw;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q.cnt)); // R2
    AST_RAW_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(raw)); // R3
    AST_CMP_LOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && state_q.cnt == '0) |=> $stable(state_q.cmp_act)); // R4
endmodule

// File: rtl/sympwm_deadband.sv
module sympwm_deadband #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             raw,
    input  logic [CNT_W-1:0] rise_dly,
    input  logic [CNT_W-1:0] fall_dly,
    input  logic [1:0]       out_sel,
    input  logic [1:0]       pol_sel,
    output logic             pwm_a,
    output logic             pwm_b
);
    typedef struct packed {
        logic [CNT_W-1:0] rcnt;
        logic [CNT_W-1:0] fcnt;
        logic             rise_o;
        logic             fall_o;
        logic             raw_d;
    } db_state_t;

    db_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.raw_d = raw;
        if (raw) begin
            state_d.fcnt = '0;
            if (tick && state_q.rcnt < rise_dly) state_d.rcnt = state_q.rcnt + CNT_W'(1);
        end else begin
            state_d.rcnt = '0;
            if (tick && state_q.fcnt < fall_dly) state_d.fcnt = state_q.fcnt + CNT_W'(1);
        end
        state_d.rise_o = raw && (state_q.rcnt >= rise_dly);
        state_d.fall_o = raw || (state_q.fcnt < fall_dly);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.rcnt   <= '0;
            state_q.fcnt   <= '1;
            state_q.rise_o <= 1'b0;
            state_q.fall_o <= 1'b0;
            state_q.raw_d  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pwm_a = pol_sel[0] ^ (out_sel[1] ? state_q.rise_o : state_q.raw_d);
    assign pwm_b = pol_sel[1] ^ (out_sel[0] ? state_q.fall_o : state_q.raw_d);

    AST_RISE_DROPS_WITH_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        !raw |=> !state_q.rise_o); // R5
    AST_FALL_HELD_BY_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        raw |=> state_q.fall_o); // R6
endmodule

// File: rtl/sympwm_event.sv
module sympwm_event #(
    parameter int EVPS_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              down_evt,
    input  logic [EVPS_W-1:0] evt_div,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              irq
);
    typedef struct packed {
        logic [EVPS_W-1:0] evcnt;
        logic              flag;
    } ev_state_t;

    ev_state_t state_d, state_q;
    logic [EVPS_W-1:0] cnt_next;
    logic fire;

    always_comb begin
        cnt_next = state_q.evcnt + EVPS_W'(1);
        fire     = down_evt && (evt_div != '0) && (cnt_next == evt_div);
        state_d  = state_q;
        if (down_evt && evt_div != '0) state_d.evcnt = fire ? '0 : cnt_next;
        state_d.flag = fire || (state_q.flag && !irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign irq = state_q.flag && irq_en;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.flag && !irq_clr) |=> state_q.flag); // R9
    AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_div == '0 && !state_q.flag) |=> !state_q.flag); // R8
endmodule

// File: rtl/sympwm_db.sv
module sympwm_db #(
    parameter int CNT_W   = 16,
    parameter int CKDIV_W = 3,
    parameter int HSP_W   = 3,
    parameter int EVPS_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CKDIV_W-1:0] clk_div_sel,
    input  logic [HSP_W-1:0]   hs_div_sel,
    input  logic [CNT_W-1:0]   period,
    input  logic [CNT_W-1:0]   cmp_val,
    input  logic [CNT_W-1:0]   rise_dly,
    input  logic [CNT_W-1:0]   fall_dly,
    input  logic [1:0]         out_sel,
    input  logic [1:0]         pol_sel,
    input  logic [EVPS_W-1:0]  evt_div,
    input  logic               irq_en,
    input  logic               irq_clr,
    output logic               pwm_a,
    output logic               pwm_b,
    output logic               irq
);
    logic tick;
    logic raw;
    logic down_evt;

    sympwm_prescale #(.CKDIV_W(CKDIV_W), .HSP_W(HSP_W)) u_prescale (
        .clk(clk), .rst_n(rst_n), .clk_div_sel(clk_div_sel),
        .hs_div_sel(hs_div_sel), .tick(tick)
    );

    sympwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
        .cmp_val(cmp_val), .raw(raw), .down_evt(down_evt)
    );

    sympwm_deadband #(.CNT_W(CNT_W)) u_deadband (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(raw),
        .rise_dly(rise_dly), .fall_dly(fall_dly), .out_sel(out_sel),
        .pol_sel(pol_sel), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    sympwm_event #(.EVPS_W(EVPS_W)) u_event (
        .clk(clk), .rst_n(rst_n), .down_evt(down_evt), .evt_div(evt_div),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq)
    );
endmodule

// File: tb/sympwm_db_bench.sv
module sympwm_db_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  clk_div_sel = '0;
    logic [2:0]  hs_div_sel = '0;
    logic [15:0] period = 16'd8;
    logic [15:0] cmp_val = 16'd4;
    logic [15:0] rise_dly = '0;
    logic [15:0] fall_dly = '0;
    logic [1:0]  out_sel = '0;
    logic [1:0]  pol_sel = '0;
    logic [1:0]  evt_div = 2'd1;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic        pwm_a, pwm_b, irq;

    int checks = 0;
    int errors = 0;
    localparam int MAXW = 4000;

    always #4 clk = ~clk;

    sympwm_db u_sympwm_db (
        .clk(clk), .rst_n(rst_n), .clk_div_sel(clk_div_sel), .hs_div_sel(hs_div_sel),
        .period(period), .cmp_val(cmp_val), .rise_dly(rise_dly), .fall_dly(fall_dly),
        .out_sel(out_sel), .pol_sel(pol_sel), .evt_div(evt_div), .irq_en(irq_en),
        .irq_clr(irq_clr), .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int sel);
        return (sel == 0) ? pwm_a : (sel == 1) ? pwm_b : irq;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic meas(input int sel, output int hi, output int lo);
        int guard;
        hi = 0; lo = 0; guard = 0;
        while (sig(sel) == 1'b1 && guard < MAXW) begin @(negedge clk); guard++; end
        while (sig(sel) == 1'b0 && guard < MAXW) begin @(negedge clk); guard++; end
        while (sig(sel) == 1'b1 && guard < MAXW) begin @(negedge clk); hi++; guard++; end
        while (sig(sel) == 1'b0 && guard < MAXW) begin @(negedge clk); lo++; guard++; end
        if (guard >= MAXW) begin hi = -1; lo = -1; end
    endtask

    task automatic count_high(input int sel, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sig(sel)) cnt++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; pol_sel = 2'b00;
        repeat (2) @(negedge clk);
        chk("R10 pwm_a in reset", int'(pwm_a), 0);
        chk("R10 pwm_b in reset", int'(pwm_b), 0);
        chk("R10 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        int hi, lo;
        period = 8; cmp_val = 4; out_sel = 0; pol_sel = 0; clk_div_sel = 0; hs_div_sel = 0;
        do_reset();
        meas(0, hi, lo);
        chk("R3 high P8 C4", hi, 8);
        chk("R2 low P8 C4", lo, 8);
        meas(1, hi, lo);
        chk("R7 B undelayed high", hi, 8);
        period = 10; cmp_val = 3;
        do_reset();
        meas(0, hi, lo);
        meas(0, hi, lo);
        chk("R3 high P10 C3", hi, 14);
        chk("R3 low P10 C3", lo, 6);
    endtask

    task automatic t_polarity();
        int hi, lo;
        period = 10; cmp_val = 3; out_sel = 0; pol_sel = 2'b01;
        do_reset();
        meas(0, hi, lo);
        meas(0, hi, lo);
        chk("R7 A inverted high", hi, 6);
        chk("R7 A inverted low", lo, 14);
        meas(1, hi, lo);
        chk("R7 B plain high", hi, 14);
    endtask

    task automatic t_prescale();
        int hi, lo;
        period = 5; cmp_val = 2; out_sel = 0; pol_sel = 0;
        clk_div_sel = 1; hs_div_sel = 1;
        do_reset();
        meas(0, hi, lo);
        meas(0, hi, lo);
        chk("R1 ratio4 high", hi, 24);
        chk("R1 ratio4 low", lo, 16);
        period = 3; cmp_val = 1; clk_div_sel = 2; hs_div_sel = 3;
        do_reset();
        meas(0, hi, lo);
        meas(0, hi, lo);
        chk("R1 ratio24 high", hi, 96);
        chk("R1 ratio24 period", hi + lo, 144);
        clk_div_sel = 0; hs_div_sel = 0;
    endtask

    task automatic t_shadow();
        int hi, lo, guard;
        period = 8; cmp_val = 4; out_sel = 0; pol_sel = 0;
        do_reset();
        meas(0, hi, lo);
        chk("R3 shadow baseline high", hi, 8);
        guard = 0;
        while (pwm_a == 1'b1 && guard < MAXW) begin @(negedge clk); guard++; end
        while (pwm_a == 1'b0 && guard < MAXW) begin @(negedge clk); guard++; end
        cmp_val = 6;
        hi = 0;
        while (pwm_a == 1'b1 && guard < MAXW) begin @(negedge clk); hi++; guard++; end
        chk("R4 pulse in progress keeps width", hi, 8);
        meas(0, hi, lo);
        chk("R4 new compare high", hi, 4);
        chk("R4 new compare low", lo, 12);
    endtask

    task automatic t_rise();
        int hi, lo, cnt;
        period = 8; cmp_val = 4; out_sel = 2'b10; pol_sel = 0; rise_dly = 3;
        do_reset();
        meas(0, hi, lo);
        chk("R5 delayed high", hi, 5);
        chk("R5 delayed low", lo, 11);
        cmp_val = 6; rise_dly = 4;
        do_reset();
        count_high(0, 64, cnt);
        chk("R5 pulse equal to delay suppressed", cnt, 0);
        rise_dly = 3;
        do_reset();
        meas(0, hi, lo);
        chk("R5 pulse one tick longer than delay", hi, 1);
    endtask

    task automatic t_complementary();
        int hi, lo, overlap;
        period = 8; cmp_val = 4; out_sel = 2'b11; pol_sel = 2'b10;
        rise_dly = 2; fall_dly = 3;
        do_reset();
        meas(0, hi, lo);
        chk("R6 A high with rise delay", hi, 6);
        chk("R6 A low", lo, 10);
        meas(1, hi, lo);
        chk("R6 B high with fall delay", hi, 5);
        chk("R6 B low", lo, 11);
        overlap = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (pwm_a && pwm_b) overlap++;
        end
        chk("R6 no overlap", overlap, 0);
        rise_dly = 0; fall_dly = 0; out_sel = 0; pol_sel = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic irq_gap(output int gap);
        int guard;
        guard = 0;
        pulse_clr();
        while (irq == 1'b0 && guard < MAXW) begin @(negedge clk); guard++; end
        irq_clr = 1'b1;
        gap = 1;
        @(negedge clk);
        irq_clr = 1'b0;
        while (irq == 1'b0 && gap < MAXW) begin @(negedge clk); gap++; end
    endtask

    task automatic t_event();
        int gap, cnt;
        period = 8; cmp_val = 4; irq_en = 1'b1; evt_div = 1;
        do_reset();
        irq_gap(gap);
        chk("R8 every event", gap, 16);
        evt_div = 2;
        do_reset();
        irq_gap(gap);
        chk("R8 every second event", gap, 32);
        evt_div = 3;
        do_reset();
        irq_gap(gap);
        chk("R8 every third event", gap, 48);
        evt_div = 0;
        do_reset();
        count_high(2, 100, cnt);
        chk("R8 divider zero never fires", cnt, 0);
        evt_div = 1;
        do_reset();
        cnt = 0;
        while (irq == 1'b0 && cnt < MAXW) begin @(negedge clk); cnt++; end
        count_high(2, 50, cnt);
        chk("R9 flag sticky without clear", cnt, 50);
        irq_en = 1'b0;
        count_high(2, 50, cnt);
        chk("R9 irq gated by enable", cnt, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R9 pending flag shows on enable", int'(irq), 1);
        irq_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_polarity();
        t_prescale();
        t_shadow();
        t_rise();
        t_complementary();
        t_event();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule